// File: doc/BRIEF.md
# Input Capture Unit with Run-Length Noise Filter

This block watches an asynchronous capture pin and, on a chosen transition of that pin, takes a snapshot of a free-running 16-bit counter that is supplied from outside the block. The pin first passes through a synchronizer. It can then go through an optional run-length filter, which lets a level change through only after the synchronized pin has held the new level for four samples in a row. The edge detector runs on the resulting level. The edge polarity that triggers a capture can be programmed. A capture writes the counter value into a capture register and sets a sticky capture flag, which stays set until software clears it with a strobe.

Configuration is held in one control byte. That byte carries the filter enable, the edge polarity, a reserved bit, two waveform mode bits and three clock-select bits. The mode and clock-select bits are stored and read back for use by the counter logic next to this block, but this block does not act on them. The counter itself and any interrupt logic are outside this block.

Top module: `icap_unit`

## Requirements
- R1: After reset, `ctrl_rdata` reads 0x00, `cap_flag` is 0 and `cap_value` is 0x0000.
- R2: A `ctrl_wr` pulse stores `ctrl_wdata` into the control byte. The byte has this layout: bit 7 is the filter enable, bit 6 is the edge polarity, bits 4:3 are the mode bits and bits 2:0 are the clock select. Bit 5 always reads 0, whatever is written to it.
- R3: With the filter off (bit 7 = 0), consider a pin change driven before clock edge k. The pin goes through a two-flop synchronizer. The capture register then loads the `cnt_val` present between edges k+1 and k+2. `cap_flag` reads 1 after edge k+2 and not before.
- R4: When bit 6 is 1, a capture is triggered by a rising edge of the conditioned pin. When bit 6 is 0, a capture is triggered by a falling edge. An edge of the opposite direction leaves `cap_flag` and `cap_value` unchanged.
- R5: With the filter on (bit 7 = 1), the conditioned level changes only after four consecutive synchronized samples agree on the new level. For a pin change driven before edge k, the capture therefore loads the `cnt_val` present between edges k+5 and k+6. This is exactly four cycles later than R3.
- R6: With the filter on, a pin pulse that lasts fewer than four clock cycles never causes a capture.
- R7: Writing a new edge polarity while the pin is steady does not cause a capture.
- R8: A `flag_clr` pulse with no capture in the same cycle clears `cap_flag` after that edge. `cap_value` holds its value until the next capture.
- R9: If `flag_clr` and a capture fall on the same clock edge, the capture wins: `cap_flag` stays 1 and the new value is stored.
- R10: A capture that occurs while `cap_flag` is already 1 overwrites `cap_value` with the new counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_raw | input | 1 | Asynchronous capture pin |
| cnt_val | input | 16 | Current counter value to snapshot |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| flag_clr | input | 1 | Capture flag clear strobe |
| cap_value | output | 16 | Captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| ctrl_rdata | output | 8 | Control byte readback |

## Verification
A capture and a software flag clear can land on the same clock edge, and the block must then let the capture win. The bench provokes this in two steps. It first sets the flag with a capture. It then drives a second pin edge and asserts `flag_clr` during exactly the cycle whose closing edge stores the counter value. The bench counts this cycle from the synchronizer latency. After that edge it requires the flag to be still set and the capture register to hold the new counter value. A separate case, in which a clear arrives with no pin activity, shows that the clear does work on its own.

// File: rtl/icap_pkg.sv
package icap_pkg;

   localparam int CTRL_W = 8;

   // Control byte layout; field order is the bit order of the byte.
   typedef struct packed {
      logic       flt_en;     // bit 7: run-length filter on
      logic       edge_rise;  // bit 6: 1 = rising, 0 = falling
      logic       rsv;        // bit 5: reserved, reads 0
      logic [1:0] wave_hi;    // bits 4:3: mode bits (stored only)
      logic [2:0] clk_sel;    // bits 2:0: clock select (stored only)
   } icap_ctrl_t;

   localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 8'hDF;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("icap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/icap_runfilt.sv
module icap_runfilt #(
   parameter int RUN_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (RUN_LEN < 2) begin : g_bad_len
      $error("icap_runfilt: RUN_LEN must be at least 2");
   end

   logic [RUN_LEN-1:0] hist;
   logic               held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         held <= 1'b0;
      end else begin
         hist <= {hist[RUN_LEN-2:0], din};
         held <= dout;
      end
   end

   // Output follows the history only when every stored sample agrees.
   always_comb begin
      if (&hist)       dout = 1'b1;
      else if (~|hist) dout = 1'b0;
      else             dout = held;
   end

endmodule

// File: rtl/icap_edge_det.sv
module icap_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   output logic evt
);

   logic lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   // The history register does not depend on polarity, so a polarity
   // change alone cannot produce an event.
   assign evt = rise_sel ? (lvl & ~lvl_d) : (~lvl & lvl_d);

endmodule

// File: rtl/icap_ctrl_reg.sv
module icap_ctrl_reg
   import icap_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   output icap_ctrl_t        ctrl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl <= '0;
      else if (wr) ctrl <= icap_ctrl_t'(wdata & CTRL_WR_MASK);
   end

endmodule

// File: rtl/icap_unit.sv
module icap_unit
   import icap_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter int RUN_LEN     = 4,
   parameter bit HAS_FILTER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_raw,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              flag_clr,
   output logic [CNT_W-1:0]  cap_value,
   output logic              cap_flag,
   output logic [CTRL_W-1:0] ctrl_rdata
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("icap_unit: CNT_W must be positive");
   end

   icap_ctrl_t ctrl_q;
   logic       sync_lvl;
   logic       filt_lvl;
   logic       sel_lvl;
   logic       cap_evt;

   icap_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctrl_wr),
      .wdata (ctrl_wdata),
      .ctrl  (ctrl_q)
   );

   icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (sync_lvl)
   );

   if (HAS_FILTER) begin : g_filter
      icap_runfilt #(.RUN_LEN(RUN_LEN)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (sync_lvl),
         .dout  (filt_lvl)
      );
      assign sel_lvl = ctrl_q.flt_en ? filt_lvl : sync_lvl;
   end else begin : g_nofilter
      assign filt_lvl = sync_lvl;
      assign sel_lvl  = sync_lvl;
   end

   icap_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (sel_lvl),
      .rise_sel (ctrl_q.edge_rise),
      .evt      (cap_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_value <= '0;
         cap_flag  <= 1'b0;
      end else begin
         if (cap_evt) cap_value <= cnt_val;
         if (cap_evt)       cap_flag <= 1'b1;
         else if (flag_clr) cap_flag <= 1'b0;
      end
   end

   assign ctrl_rdata = ctrl_q;

endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
   parameter int CNT_W      = 16,
   parameter int RUN_LEN    = 4,
   parameter bit HAS_FILTER = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] cnt_val,
   input logic             flag_clr,
   input logic [CNT_W-1:0] cap_value,
   input logic             cap_flag,
   input logic [7:0]       ctrl_rdata,
   input logic             cap_evt,
   input logic             edge_rise,
   input logic             sel_lvl,
   input logic             sync_lvl,
   input logic             filt_lvl
);

   assert_capture_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_flag && cap_value == $past(cnt_val)));

   assert_polarity_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> (sel_lvl == edge_rise));

   assert_steady_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_lvl == $past(sel_lvl)) |-> !cap_evt);

   assert_value_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> $stable(cap_value));

   assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !cap_evt) |=> !cap_flag);

   assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && cap_evt) |=> cap_flag);

   assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rdata[5] == 1'b0);

   if (HAS_FILTER && RUN_LEN == 4) begin : g_filt_chk
      assert_filter_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(filt_lvl) |->
            ($past(sync_lvl, 1) == filt_lvl && $past(sync_lvl, 2) == filt_lvl &&
             $past(sync_lvl, 3) == filt_lvl && $past(sync_lvl, 4) == filt_lvl));
   end

endmodule

bind icap_unit icap_unit_chk #(
   .CNT_W      (CNT_W),
   .RUN_LEN    (RUN_LEN),
   .HAS_FILTER (HAS_FILTER)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cnt_val    (cnt_val),
   .flag_clr   (flag_clr),
   .cap_value  (cap_value),
   .cap_flag   (cap_flag),
   .ctrl_rdata (ctrl_rdata),
   .cap_evt    (cap_evt),
   .edge_rise  (ctrl_q.edge_rise),
   .sel_lvl    (sel_lvl),
   .sync_lvl   (sync_lvl),
   .filt_lvl   (filt_lvl)
);

// File: tb/icap_unit_tb_top.sv
module icap_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_raw = 1'b0;
   logic [15:0] cnt_val;
   logic        ctrl_wr = 1'b0;
   logic [7:0]  ctrl_wdata = 8'h00;
   logic        flag_clr = 1'b0;
   logic [15:0] cap_value;
   logic        cap_flag;
   logic [7:0]  ctrl_rdata;

   int unsigned cyc = 0;
   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   always_ff @(posedge clk) cyc <= cyc + 1;
   assign cnt_val = 16'h1000 + cyc[15:0];

   icap_unit dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_raw    (pin_raw),
      .cnt_val    (cnt_val),
      .ctrl_wr    (ctrl_wr),
      .ctrl_wdata (ctrl_wdata),
      .flag_clr   (flag_clr),
      .cap_value  (cap_value),
      .cap_flag   (cap_flag),
      .ctrl_rdata (ctrl_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctrl(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      tick(1);
      ctrl_wr = 1'b0;
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
      chk("R8 flag cleared", {31'd0, cap_flag}, 32'd1 - 32'd1);
   endtask

   // Drive a pin change and expect a capture after lat cycles.
   task automatic expect_capture(input string tag, input logic lvl, input int lat,
                                 input logic pre_flag, input bit clr_same);
      logic [15:0] exp;
      pin_raw = lvl;
      exp = 16'h1000 + cyc[15:0] + lat[15:0];
      tick(lat);
      chk({tag, " flag before capture edge"}, {31'd0, cap_flag}, {31'd0, pre_flag});
      if (clr_same) flag_clr = 1'b1;
      tick(1);
      flag_clr = 1'b0;
      chk({tag, " flag"}, {31'd0, cap_flag}, 32'd1);
      chk({tag, " value"}, {16'd0, cap_value}, {16'd0, exp});
   endtask

   task automatic expect_none(input string tag, input int wait_n);
      logic [15:0] prev;
      prev = cap_value;
      tick(wait_n);
      chk({tag, " flag"}, {31'd0, cap_flag}, 32'd0);
      chk({tag, " value"}, {16'd0, cap_value}, {16'd0, prev});
   endtask

   task automatic t_reset();
      chk("R1 ctrl", {24'd0, ctrl_rdata}, 32'h00);
      chk("R1 flag", {31'd0, cap_flag}, 32'd0);
      chk("R1 value", {16'd0, cap_value}, 32'h0);
   endtask

   task automatic t_ctrl();
      write_ctrl(8'hFF); chk("R2 ff readback", {24'd0, ctrl_rdata}, 32'hDF);
      write_ctrl(8'h5A); chk("R2 5a readback", {24'd0, ctrl_rdata}, 32'h5A);
      write_ctrl(8'h20); chk("R2 reserved only", {24'd0, ctrl_rdata}, 32'h00);
      write_ctrl(8'h1B); chk("R2 mode and clock", {24'd0, ctrl_rdata}, 32'h1B);
   endtask

   task automatic t_rise_unfilt();
      write_ctrl(8'h40);
      tick(6);
      expect_capture("R3 rising unfiltered", 1'b1, 2, 1'b0, 1'b0);
   endtask

   task automatic t_polarity();
      clear_flag();
      pin_raw = 1'b0;
      expect_none("R4 falling ignored with rising select", 8);
      write_ctrl(8'h00);
      pin_raw = 1'b1;
      expect_none("R4 rising ignored with falling select", 8);
      expect_capture("R4 falling captured", 1'b0, 2, 1'b0, 1'b0);
   endtask

   task automatic t_sel_toggle();
      clear_flag();
      write_ctrl(8'h40);
      write_ctrl(8'h00);
      write_ctrl(8'h40);
      expect_none("R7 polarity write with steady pin", 6);
   endtask

   task automatic t_filter();
      write_ctrl(8'hC0);
      tick(6);
      pin_raw = 1'b1; tick(3); pin_raw = 1'b0;
      expect_none("R6 three-cycle pulse rejected", 12);
      pin_raw = 1'b1; tick(1); pin_raw = 1'b0; tick(1); pin_raw = 1'b1; tick(2);
      pin_raw = 1'b0;
      expect_none("R6 broken pulses rejected", 12);
      expect_capture("R5 filtered rising", 1'b1, 6, 1'b0, 1'b0);
   endtask

   task automatic t_clear();
      logic [15:0] held;
      held = cap_value;
      tick(4);
      clear_flag();
      tick(4);
      chk("R8 value held after clear", {16'd0, cap_value}, {16'd0, held});
      chk("R8 flag stays clear", {31'd0, cap_flag}, 32'd0);
   endtask

   task automatic t_coincide();
      write_ctrl(8'h00);
      tick(6);
      expect_capture("R10 setup falling", 1'b0, 2, 1'b0, 1'b0);
      write_ctrl(8'h40);
      tick(3);
      expect_capture("R9 clear same edge as capture", 1'b1, 2, 1'b1, 1'b1);
      write_ctrl(8'h00);
      tick(3);
      expect_capture("R10 overwrite while flag set", 1'b0, 2, 1'b1, 1'b0);
   endtask

   initial begin
      tick(5);
      rst_n = 1'b1;
      tick(2);
      t_reset();
      t_ctrl();
      t_rise_unfilt();
      t_polarity();
      t_sel_toggle();
      t_filter();
      t_clear();
      t_coincide();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule